// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor whose low address byte and data byte travel on one shared set of lines. The core hands it one request at a time: a cycle kind, a 16-bit address and a write byte. The sequencer then steps through T-states. In the first T-state an address latch strobe lets outside logic capture the low address byte from the shared lines. After that the shared lines carry data, and a dedicated output holds the high address byte for the whole cycle.

The active-low read, write and memory/IO select lines follow the cycle kind, and so do the two status lines. For read and fetch cycles the byte on the shared lines is captured when the read strobe ends. It is returned with a one-cycle done pulse in the clock after the last T-state. A new request is taken only while the sequencer is idle, which includes the done cycle, so cycles can run back to back.

Top module: `busSeqTop`

## Requirements
- R1: After the synchronous reset, and whenever no cycle is running, the outputs are: ale=0, adOe=0 (shared lines released), rdN=1, wrN=1, ioMemN=1, s1=0, s0=0, highAddr=0, busy=0 and done=0. rdData resets to 0.
- R2: reqKind encodes the cycle kind: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. An accepted fetch runs four T-states and every other kind runs three. busy is high in every T-state. done is high for exactly the one clock after the last T-state.
- R3: ale is high only in T1. In T1 adOe is high and adOut carries the low address byte.
- R4: highAddr carries the high address byte in every T-state of a memory cycle.
- R5: In fetch and read cycles, rdN is low in T2 and T3 only, adOe is low from T2 onward, and wrN stays high. In the fourth T-state of a fetch, rdN is high again.
- R6: In write cycles, wrN is low in T2 and T3, adOe is high with adOut equal to the write byte in those T-states, and rdN stays high.
- R7: During a cycle, ioMemN is 0 for kinds 0, 1 and 2, and 1 for kinds 3 and 4.
- R8: During a cycle, {s1,s0} is 2'b11 for a fetch, 2'b10 for memory or I/O reads, and 2'b01 for memory or I/O writes.
- R9: In I/O cycles, the port number reqAddr[7:0] appears on both adOut (in T1) and highAddr.
- R10: In read and fetch cycles, rdData takes the adIn value present at the clock edge that ends T3 and shows it from the done cycle on. rdData holds its value through write cycles and until the next read.
- R11: A request made while busy is high, or a request with a kind code of 5, 6 or 7, is ignored. It changes no output.
- R12: A request presented in the done cycle is accepted, and its T1 follows the done cycle directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqKind | input | 3 | Cycle kind code |
| reqAddr | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| reqWrData | input | 8 | Byte to write |
| busy | output | 1 | A cycle is in its T-states |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Last byte read |
| ale | output | 1 | Address latch strobe |
| adOut | output | 8 | Shared lines, driven value |
| adOe | output | 1 | Shared lines output enable (0 = high impedance) |
| adIn | input | 8 | Shared lines, received value |
| highAddr | output | 8 | High address byte |
| ioMemN | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The hardest situation to reach is a request that arrives while a cycle is in progress. The stimulus holds reqValid high through every T-state of a read, with a different kind, address and data on the inputs. Every bus output is then compared against the unchanged expected trace. Back-to-back cycles come from the driver issuing each request in the done cycle of the previous one. The read-capture edge is isolated by having the bench put the test byte on adIn only while rdN is low, so a capture one edge late picks up a different filler byte.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MEMRD = 3'd1,
    KIND_MEMWR = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } cycKind_e;

  localparam logic [2:0] KIND_MAX = 3'd4;

  // strobes from the control to the datapath
  typedef struct packed {
    logic       active;      // inside the T-states
    logic       addrPhase;   // T1
    logic       readPhase;   // read strobe low
    logic       writePhase;  // write strobe low
    logic       ioSel;       // cycle targets I/O space
    logic [1:0] status;      // {s1,s0}
    logic       load;        // capture the request
    logic       loadIo;      // request is an I/O cycle
    logic       sample;      // capture read data at this edge
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import bus_seq_pkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(FETCH_T + 1);
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_T);
  localparam logic [CNT_W-1:0] XFER_LAST  = CNT_W'(XFER_T);
  localparam logic [CNT_W-1:0] FIRST_T    = CNT_W'(1);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(2);

  logic [CNT_W-1:0] tIdx;   // 0 = idle, else T-state number
  cycKind_e         kindQ;
  logic             doneQ;
  logic             accept;
  logic             reqIsIo;
  logic [CNT_W-1:0] lastT;
  logic             isRead;
  logic             isWrite;
  logic             dataPhase;

  assign accept  = reqValid && (reqKind <= KIND_MAX) && (tIdx == '0);
  assign reqIsIo = (reqKind == KIND_IORD) || (reqKind == KIND_IOWR);
  assign lastT   = (kindQ == KIND_FETCH) ? FETCH_LAST : XFER_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      tIdx  <= '0;
      kindQ <= KIND_FETCH;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        tIdx  <= FIRST_T;
        kindQ <= cycKind_e'(reqKind);
      end else if (tIdx != '0) begin
        if (tIdx == lastT) begin
          tIdx  <= '0;
          doneQ <= 1'b1;
        end else begin
          tIdx <= tIdx + FIRST_T;
        end
      end
    end
  end

  assign isRead    = (kindQ == KIND_FETCH) || (kindQ == KIND_MEMRD) || (kindQ == KIND_IORD);
  assign isWrite   = (kindQ == KIND_MEMWR) || (kindQ == KIND_IOWR);
  assign dataPhase = (tIdx >= DATA_FIRST) && (tIdx <= XFER_LAST);

  always_comb begin
    strobe.active     = (tIdx != '0);
    strobe.addrPhase  = (tIdx == FIRST_T);
    strobe.readPhase  = dataPhase && isRead;
    strobe.writePhase = dataPhase && isWrite;
    strobe.ioSel      = (kindQ == KIND_IORD) || (kindQ == KIND_IOWR);
    if (kindQ == KIND_FETCH)  strobe.status = 2'b11;
    else if (isRead)          strobe.status = 2'b10;
    else                      strobe.status = 2'b01;
    strobe.load       = accept;
    strobe.loadIo     = accept && reqIsIo;
    strobe.sample     = (tIdx == XFER_LAST) && isRead;
  end

  assign busy = (tIdx != '0);
  assign done = doneQ;

  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));  // R2

  AST_ACCEPT_STARTS_T1: assert property (@(posedge clk) disable iff (rst)
    accept |=> strobe.addrPhase);  // R12

  AST_KIND_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(kindQ));  // R11

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobe_t            strobe,
  input  logic [2*DATA_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]     reqWrData,
  input  logic [DATA_W-1:0]     adIn,
  output logic                  ale,
  output logic [DATA_W-1:0]     adOut,
  output logic                  adOe,
  output logic [DATA_W-1:0]     highAddr,
  output logic                  ioMemN,
  output logic                  rdN,
  output logic                  wrN,
  output logic                  s1,
  output logic                  s0,
  output logic [DATA_W-1:0]     rdData
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (strobe.load) begin
        addrQ   <= strobe.loadIo ? {reqAddr[DATA_W-1:0], reqAddr[DATA_W-1:0]} : reqAddr;
        wrDataQ <= reqWrData;
      end
      if (strobe.sample) begin
        rdDataQ <= adIn;
      end
    end
  end

  always_comb begin
    ale      = strobe.addrPhase;
    adOe     = strobe.addrPhase || strobe.writePhase;
    if (strobe.addrPhase)       adOut = addrQ[DATA_W-1:0];
    else if (strobe.writePhase) adOut = wrDataQ;
    else                        adOut = '0;
    highAddr = strobe.active ? addrQ[ADDR_W-1:DATA_W] : '0;
    ioMemN   = strobe.active ? strobe.ioSel : 1'b1;
    rdN      = !strobe.readPhase;
    wrN      = !strobe.writePhase;
    {s1, s0} = strobe.active ? strobe.status : 2'b00;
  end

  assign rdData = rdDataQ;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> wrN);  // R5

  AST_RD_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    !rdN |-> !adOe);  // R5

  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> adOe);  // R6

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);  // R3

  AST_HIGH_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobe.active && !strobe.addrPhase) |-> $stable(highAddr));  // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.sample |=> $stable(rdData));  // R10

endmodule

// File: rtl/busSeqTop.sv
module busSeqTop
  import bus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqWrData,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdData,
  output logic        ale,
  output logic [7:0]  adOut,
  output logic        adOe,
  input  logic [7:0]  adIn,
  output logic [7:0]  highAddr,
  output logic        ioMemN,
  output logic        rdN,
  output logic        wrN,
  output logic        s1,
  output logic        s0
);

  seqStrobe_t strobe;

  busSeqCtrl #(.FETCH_T(4), .XFER_T(3)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .strobe(strobe), .busy(busy), .done(done)
  );

  busSeqDatapath #(.DATA_W(8)) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .adIn(adIn), .ale(ale), .adOut(adOut),
    .adOe(adOe), .highAddr(highAddr), .ioMemN(ioMemN), .rdN(rdN),
    .wrN(wrN), .s1(s1), .s0(s0), .rdData(rdData)
  );

endmodule

// File: tb/tb_busSeqTop.sv
`timescale 1ns/1ps
module tb_busSeqTop;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWrData = 8'h0;
  logic        busy, done, ale, adOe, ioMemN, rdN, wrN, s1, s0;
  logic [7:0]  rdData, adOut, adIn, highAddr;
  logic [7:0]  busValue = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  // the memory/port model drives the test byte only while rdN is low
  assign adIn = rdN ? 8'hEE : busValue;

  busSeqTop dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .busy(busy), .done(done),
    .rdData(rdData), .ale(ale), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .highAddr(highAddr), .ioMemN(ioMemN), .rdN(rdN), .wrN(wrN),
    .s1(s1), .s0(s0)
  );

  typedef struct {
    logic       ale, adOe, ioMemN, rdN, wrN, s1, s0, busy, done, chkData;
    logic [7:0] adOut, highAddr, rdData;
    string      hiTag, loTag, note;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    failures = 0;
  bit    monOn = 1'b0;
  string idleTag = "R1";
  logic [7:0] lastRead = 8'h00;

  task automatic chk(input bit ok, input string req, input string field,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, field, act, exp);
    end
  endtask

  // monitor: one expected item per clock, idle expectation when queue empty
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (q.size() != 0) begin
          exp_t e;
          e = q.pop_front();
          chk(ale === e.ale, {"R3", e.note}, "ale", int'(ale), int'(e.ale));
          chk(adOe === e.adOe, {"R3/R5/R6", e.note}, "adOe", int'(adOe), int'(e.adOe));
          if (e.adOe)
            chk(adOut === e.adOut, {e.loTag, e.note}, "adOut", int'(adOut), int'(e.adOut));
          chk(highAddr === e.highAddr, {e.hiTag, e.note}, "highAddr", int'(highAddr), int'(e.highAddr));
          chk(ioMemN === e.ioMemN, {"R7", e.note}, "ioMemN", int'(ioMemN), int'(e.ioMemN));
          chk(rdN === e.rdN, {"R5", e.note}, "rdN", int'(rdN), int'(e.rdN));
          chk(wrN === e.wrN, {"R6", e.note}, "wrN", int'(wrN), int'(e.wrN));
          chk({s1, s0} === {e.s1, e.s0}, {"R8", e.note}, "status", int'({s1, s0}), int'({e.s1, e.s0}));
          chk(busy === e.busy, {"R2", e.note}, "busy", int'(busy), int'(e.busy));
          chk(done === e.done, {"R2", e.note}, "done", int'(done), int'(e.done));
          if (e.chkData)
            chk(rdData === e.rdData, {"R10", e.note}, "rdData", int'(rdData), int'(e.rdData));
        end else begin
          chk(ale === 1'b0 && adOe === 1'b0 && rdN === 1'b1 && wrN === 1'b1,
              idleTag, "idle strobes", int'({ale, adOe, rdN, wrN}), 'b0011);
          chk(ioMemN === 1'b1 && {s1, s0} === 2'b00 && highAddr === 8'h00,
              idleTag, "idle select/status/high", int'({ioMemN, s1, s0, highAddr}), 'h400);
          chk(busy === 1'b0 && done === 1'b0, idleTag, "idle busy/done",
              int'({busy, done}), 0);
        end
      end
    end
  end

  task automatic waitEmpty();
    forever begin
      @(negedge clk);
      #1;
      if (q.size() == 0) break;
    end
  endtask

  task automatic runCycle(input int kind, input logic [15:0] addr,
                          input logic [7:0] wd, input logic [7:0] bv,
                          input bit junk, input string note);
    int   n;
    bit   io, rd, wr;
    logic [7:0] hi, lo;
    logic [1:0] st;
    exp_t e;
    waitEmpty();
    #1;
    busValue  = bv;
    reqValid  = 1'b1;
    reqKind   = 3'(kind);
    reqAddr   = addr;
    reqWrData = wd;
    n  = (kind == 0) ? 4 : 3;
    io = (kind == 3) || (kind == 4);
    rd = (kind == 0) || (kind == 1) || (kind == 3);
    wr = (kind == 2) || (kind == 4);
    lo = addr[7:0];
    hi = io ? addr[7:0] : addr[15:8];
    st = (kind == 0) ? 2'b11 : (rd ? 2'b10 : 2'b01);
    for (int t = 1; t <= n; t++) begin
      e.ale = (t == 1);
      e.adOe = (t == 1) || (wr && t >= 2 && t <= 3);
      e.adOut = (t == 1) ? lo : wd;
      e.highAddr = hi;
      e.ioMemN = io;
      e.rdN = !(rd && t >= 2 && t <= 3);
      e.wrN = !(wr && t >= 2 && t <= 3);
      {e.s1, e.s0} = st;
      e.busy = 1'b1;
      e.done = 1'b0;
      e.chkData = 1'b0;
      e.rdData = 8'h00;
      e.hiTag = io ? "R9" : "R4";
      e.loTag = (t == 1) ? (io ? "R9" : "R3") : "R6";
      e.note = note;
      q.push_back(e);
    end
    if (rd) lastRead = bv;
    e.ale = 1'b0; e.adOe = 1'b0; e.adOut = 8'h00; e.highAddr = 8'h00;
    e.ioMemN = 1'b1; e.rdN = 1'b1; e.wrN = 1'b1; e.s1 = 1'b0; e.s0 = 1'b0;
    e.busy = 1'b0; e.done = 1'b1; e.chkData = 1'b1; e.rdData = lastRead;
    e.hiTag = "R1"; e.loTag = "R1"; e.note = note;
    q.push_back(e);
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      #2;
      if (junk) begin
        reqValid  = 1'b1;
        reqKind   = (kind == 0) ? 3'd2 : 3'd0;
        reqAddr   = ~addr;
        reqWrData = ~wd;
      end else begin
        reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired R2 actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    #1 monOn = 1'b1;
    // R1: idle after reset, rdData at 0
    chk(rdData === 8'h00, "R1", "rdData reset", int'(rdData), 0);
    repeat (3) @(negedge clk);

    runCycle(0, 16'h1234, 8'h00, 8'hA5, 1'b0, "");        // fetch
    runCycle(1, 16'h8001, 8'h00, 8'h3C, 1'b0, " R12");    // memory read
    runCycle(2, 16'hABCD, 8'h5A, 8'h00, 1'b0, " R12");    // memory write
    runCycle(3, 16'h12F7, 8'h00, 8'h99, 1'b0, " R12");    // I/O read
    runCycle(4, 16'h4466, 8'hC3, 8'h00, 1'b0, " R12");    // I/O write

    // R11: reserved kind codes are ignored
    waitEmpty();
    idleTag = "R11";
    for (int k = 5; k <= 7; k++) begin
      #1;
      reqValid = 1'b1;
      reqKind  = 3'(k);
      reqAddr  = 16'hFFFF;
      @(negedge clk);
      #1 reqValid = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    chk(rdData === 8'h99, "R11", "rdData after reserved kinds", int'(rdData), 'h99);
    idleTag = "R1";

    // R11: requests held during a running cycle are ignored
    runCycle(1, 16'h0F0E, 8'h00, 8'h6D, 1'b1, " R11");
    runCycle(0, 16'hFEDC, 8'h11, 8'h42, 1'b1, " R11");
    runCycle(4, 16'h0081, 8'h7E, 8'h00, 1'b1, " R11");
    runCycle(2, 16'h00FF, 8'h81, 8'h00, 1'b0, " R12");

    waitEmpty();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule